// File: doc/BRIEF.md
# Configurable-resolution sample serializer

This block takes converter samples and sends them out on serial lanes at a chosen output resolution of 14, 16, 18 or 20 bits. A sample can come straight from the converter as a 16-bit raw word, or from a filter as a 20-bit word. In bypass mode the raw word is truncated or padded with zeros. In filtered mode the top bits of the 20-bit result are kept, so the low-order bits carry real data.

The formatted word is shifted out MSB first. There are three lane modes: it can be split across two lanes, sent whole on one lane, or sent at half rate on one lane that is shared with another channel. One fast clock drives the block, and each cycle of that clock is one bit slot on a lane. From the same slot counter the block makes a frame clock and a bit clock. The bit clock changes level once per slot, so lane data is taken on both of its edges. A new resolution or lane mode takes effect only at the next frame boundary.

Top module: `res_lane_serializer`

## Requirements
- R1: With `res_sel` = 00 (14 bits), the output word is `raw_sample[15:2]` in bypass mode and `filt_sample[19:6]` in filtered mode.
- R2: In bypass mode (`filt_mode` = 0), `res_sel` = 01 gives `raw_sample` unchanged. `res_sel` = 10 gives `raw_sample` followed by two zero bits, and `res_sel` = 11 gives `raw_sample` followed by four zero bits.
- R3: In filtered mode (`filt_mode` = 1), the output word is the top N bits of `filt_sample`, where N is the selected resolution. For example, 20 bits gives the whole word and 18 bits gives `filt_sample[19:2]`.
- R4: With `lane_mode` = 00 (two lanes), a sample takes N/2 slots. `lane0` carries the upper half of the word and `lane1` carries the lower half, each MSB first. One frame spans two samples (N slots).
- R5: With `lane_mode` = 01 (one lane), a sample and a frame each take N slots. `lane0` carries the word MSB first and `lane1` stays low.
- R6: With `lane_mode` = 10 or 11 (half lane), a sample and a frame each take 2N slots. `lane0` carries the word MSB first in the first N slots and stays low in the remaining N slots. `lane1` stays low.
- R7: `frame_clk` is high for the first half of the slots of each frame and low for the second half. It rises on the first slot of a frame.
- R8: `bit_clk` changes level on every slot and is high on the first slot of each frame, so each lane bit lines up with one bit-clock edge.
- R9: The word sent in a sample period comes from the last sample captured by `sample_valid` before that period began. A sample captured on the first slot of a period is sent in the following period.
- R10: A change of `res_sel` or `lane_mode` does not alter the frame in progress. The new frame length and word format start at the next frame boundary.
- R11: During reset and on the first slot after it, the block is at the first slot of a 16-bit one-lane frame with a zero word: `frame_clk` and `bit_clk` are high, and both lanes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock, one lane bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_sample | input | 16 | Raw converter sample |
| filt_sample | input | 20 | Filtered sample |
| filt_mode | input | 1 | 1: use the filtered sample, 0: use the raw sample (bypass) |
| res_sel | input | 2 | Output resolution: 00=14, 01=16, 10=18, 11=20 bits |
| lane_mode | input | 2 | 00 two lanes, 01 one lane, 1x half lane |
| sample_valid | input | 1 | Captures the sample inputs in this cycle |
| lane0 | output | 1 | Serial data lane 0 |
| lane1 | output | 1 | Serial data lane 1 |
| frame_clk | output | 1 | Frame clock |
| bit_clk | output | 1 | DDR bit clock |

## Verification
The assertions assume that `sample_valid` pulses at most once in each sample period, well before that period's last slot. They also assume that the configuration inputs are only sampled at frame ends, so that frame length and word changes fall on slot boundaries that the counter defines. The stimulus keeps to these assumptions. It aligns to the rising edge of `frame_clk` after each configuration change, pulses `sample_valid` only on the first slot of every sample period, and waits long enough for the new configuration to apply before it checks data. Random resolutions, lane modes, per-sample path flags and sample values are mixed with all-ones and alternating-bit samples, and with directed configuration switches in the middle of a frame.

// File: rtl/res_lane_serializer.sv
module res_lane_serializer #(
  parameter int RAW_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RAW_W-1:0]   raw_sample,
  input  logic [RAW_W+3:0]   filt_sample,
  input  logic               filt_mode,
  input  logic [1:0]         res_sel,
  input  logic [1:0]         lane_mode,
  input  logic               sample_valid,
  output logic               lane0,
  output logic               lane1,
  output logic               frame_clk,
  output logic               bit_clk
);

  localparam int FW = RAW_W + 4;
  localparam int CW = $clog2(2 * FW);

  logic [CW-1:0]    cnt;
  logic [1:0]       act_res;
  logic [1:0]       act_mode;
  logic [RAW_W-1:0] hold_raw;
  logic [FW-1:0]    hold_filt;
  logic             hold_fm;
  logic [FW-1:0]    word;

  function automatic logic [CW-1:0] res_len(input logic [1:0] code);
    return CW'(RAW_W - 2 + 2 * int'(code));
  endfunction

  function automatic logic [FW-1:0] map_word(input logic [1:0] code, input logic fm,
                                             input logic [RAW_W-1:0] r, input logic [FW-1:0] f);
    int sh;
    sh = FW - (RAW_W - 2 + 2 * int'(code));
    return fm ? (f >> sh) : ({r, 4'b0000} >> sh);
  endfunction

  wire [CW-1:0] len  = res_len(act_res);
  wire          two  = (act_mode == 2'b00);
  wire          half = act_mode[1];
  wire [CW-1:0] flen = half ? (len << 1) : len;
  wire [CW-1:0] slen = two ? (len >> 1) : flen;

  wire frame_end  = (cnt == flen - 1'b1);
  wire sample_end = frame_end || (two && cnt == slen - 1'b1);

  wire [CW-1:0] pos = (two && cnt >= slen) ? cnt - slen : cnt;
  wire [CW-1:0] i0  = len - 1'b1 - pos;
  wire [CW-1:0] i1  = slen - 1'b1 - pos;
  wire [FW-1:0] sh0 = word >> i0;
  wire [FW-1:0] sh1 = word >> i1;

  assign lane0     = (pos < len) ? sh0[0] : 1'b0;
  assign lane1     = two ? sh1[0] : 1'b0;
  assign frame_clk = (cnt < (flen >> 1));
  assign bit_clk   = ~cnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_res   <= 2'b01;
      act_mode  <= 2'b01;
      word      <= '0;
      hold_raw  <= '0;
      hold_filt <= '0;
      hold_fm   <= 1'b0;
    end else begin
      if (sample_valid) begin
        hold_raw  <= raw_sample;
        hold_filt <= filt_sample;
        hold_fm   <= filt_mode;
      end
      if (frame_end) begin
        cnt      <= '0;
        act_res  <= res_sel;
        act_mode <= lane_mode;
        word     <= map_word(res_sel, hold_fm, hold_raw, hold_filt);
      end else begin
        cnt <= cnt + 1'b1;
        if (sample_end) word <= map_word(act_res, hold_fm, hold_raw, hold_filt);
      end
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(act_res) && $stable(act_mode)));

  // R7
  fclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_clk) |-> (cnt == '0));

  // R8
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bit_clk != $past(bit_clk)));

  // R6
  half_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half && cnt >= len) |-> !lane0);

  // R5
  lane1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !two |-> !lane1);

  // R9
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> $past(sample_end));

endmodule

// File: tb/res_lane_serializer_tb.sv
`timescale 1ns/1ps
module res_lane_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] raw_sample;
  logic [19:0] filt_sample;
  logic        filt_mode;
  logic [1:0]  res_sel;
  logic [1:0]  lane_mode;
  logic        sample_valid;
  logic        lane0, lane1, frame_clk, bit_clk;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  res_lane_serializer #(.RAW_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_sample(raw_sample), .filt_sample(filt_sample),
    .filt_mode(filt_mode), .res_sel(res_sel), .lane_mode(lane_mode),
    .sample_valid(sample_valid), .lane0(lane0), .lane1(lane1),
    .frame_clk(frame_clk), .bit_clk(bit_clk));

  function automatic logic [19:0] ref_word(input int res, input bit fm,
                                           input logic [15:0] r, input logic [19:0] f);
    case (res)
      14:      return fm ? {6'b0, f[19:6]} : {6'b0, r[15:2]};
      16:      return fm ? {4'b0, f[19:4]} : {4'b0, r};
      18:      return fm ? {2'b0, f[19:2]} : {2'b0, r, 2'b00};
      default: return fm ? f : {r, 4'b0000};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sync_frame();
    bit fc_prev;
    fc_prev = frame_clk;
    @(negedge clk);
    while (!(frame_clk && !fc_prev)) begin
      fc_prev = frame_clk;
      @(negedge clk);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R9
  task automatic run_cfg(input int rc, input int mc, input int nsamp);
    int res, S, F, spf;
    bit two, half, pfm, cfm, bad, fbad;
    logic [15:0] pr, cr;
    logic [19:0] pf, cf, e, t;
    logic [39:0] g0, g1;
    logic exp0, exp1;
    res  = 14 + 2 * rc;
    two  = (mc == 0);
    half = (mc >= 2);
    F    = half ? 2 * res : res;
    S    = two ? res / 2 : F;
    spf  = two ? 2 : 1;
    res_sel   = 2'(rc);
    lane_mode = 2'(mc);
    pr = '0; pf = '0; pfm = 1'b0;
    repeat (100) @(negedge clk);
    sync_frame();
    for (int k = 0; k <= nsamp; k++) begin
      case (k)
        1:       begin cr = 16'hFFFF; cf = 20'hFFFFF; end
        2:       begin cr = 16'h5555; cf = 20'hAAAAA; end
        3:       begin cr = 16'h8001; cf = 20'h80001; end
        default: begin cr = 16'($urandom); cf = 20'($urandom); end
      endcase
      cfm = 1'($urandom);
      raw_sample = cr; filt_sample = cf; filt_mode = cfm; sample_valid = 1'b1;
      e = ref_word(res, pfm, pr, pf);
      g0 = '0; g1 = '0; bad = 1'b0; fbad = 1'b0;
      for (int s = 0; s < S; s++) begin
        int idx;
        idx = (k % spf) * S + s;
        if (half && s >= res) exp0 = 1'b0;
        else begin t = e >> (res - 1 - s); exp0 = t[0]; end
        if (two) begin t = e >> (res / 2 - 1 - s); exp1 = t[0]; end
        else exp1 = 1'b0;
        if (lane0 !== exp0 || lane1 !== exp1) bad = 1'b1;
        if (frame_clk !== (idx < F / 2) || bit_clk !== (idx % 2 == 0)) fbad = 1'b1;
        g0 = {g0[38:0], lane0};
        g1 = {g1[38:0], lane1};
        @(negedge clk);
        sample_valid = 1'b0;
      end
      if (k > 0)
        check(!bad, two ? "R4" : (half ? "R6" : "R5"),
              $sformatf("res=%0d mode=%0d path=%0d lanes(l0,l1)", res, mc, pfm),
              {g0[31:0], g1[31:0]}, {44'h0, e});
      check(!fbad, "R7/R8", $sformatf("framing res=%0d mode=%0d", res, mc),
            {63'h0, fbad}, 64'h0);
      pr = cr; pf = cf; pfm = cfm;
    end
  endtask

  // R10
  task automatic switch_cfg(input int ra, input int ma, input int rb, input int mb);
    int fa, fb;
    bit bad;
    fa = (ma >= 2) ? 2 * (14 + 2 * ra) : 14 + 2 * ra;
    fb = (mb >= 2) ? 2 * (14 + 2 * rb) : 14 + 2 * rb;
    res_sel = 2'(ra); lane_mode = 2'(ma);
    repeat (100) @(negedge clk);
    sync_frame();
    @(negedge clk); @(negedge clk);
    res_sel = 2'(rb); lane_mode = 2'(mb);
    bad = 1'b0;
    for (int s = 2; s < fa; s++) begin
      if (frame_clk !== (s < fa / 2)) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R10", "old frame kept after mid-frame change", {63'h0, bad}, 64'h0);
    bad = 1'b0;
    for (int s = 0; s < fb; s++) begin
      if (frame_clk !== (s < fb / 2)) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R10", "new frame length at boundary", {63'h0, bad}, 64'h0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0;
    raw_sample = '0; filt_sample = '0; filt_mode = 1'b0;
    res_sel = 2'b01; lane_mode = 2'b01; sample_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    check(frame_clk === 1'b1 && bit_clk === 1'b1 && lane0 === 1'b0 && lane1 === 1'b0,
          "R11", "reset outputs", {60'h0, frame_clk, bit_clk, lane0, lane1}, 64'hC);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_clk === 1'b1 && bit_clk === 1'b0 && lane0 === 1'b0,
          "R11", "second slot after reset", {61'h0, frame_clk, bit_clk, lane0}, 64'h4);
    for (int rc = 0; rc < 4; rc++)
      for (int mc = 0; mc < 4; mc++)
        run_cfg(rc, mc, 6);
    switch_cfg(1, 0, 3, 2);
    switch_cfg(3, 2, 0, 1);
    switch_cfg(0, 1, 2, 0);
    for (int i = 0; i < 20; i++)
      run_cfg(int'($urandom % 4), int'($urandom % 4), 5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule